// File: doc/BRIEF.md
# Fault-Only-First Vector Load Sequencer

This block runs the element accesses of one vector load in fault-only-first mode. A start pulse supplies a base address, a vector length, a resume index and the active policy. The block then issues one address request per element, in ascending element order, to a memory or translation port. Fault responses return tagged with their element index and may come back in any order. Once every issued element has answered, the block produces one result. That result is either a trap carrying the index of the faulting element, or a completion with a possibly reduced vector length and a contiguous valid mask.

Supervisor software writes a small set of policy registers through a single write port: an always-trap bit, a probe threshold and a restrict mode. A saturating counter records how many loads ended early because of a fault. Once the counter reaches the threshold, further early-ending loads trap instead. The restrict mode can cut every fault-first load down to a single element, either always or only once the threshold has been reached.

Top module: `ffirst_load_seq`

## Requirements
- R1: A fault on the first active element traps, whatever the policy. The first active element is element 0 when the resume index is 0. On a trap, trap_o is 1, trap_idx_o is that element, new_vl_o equals the requested vl and mask_o has only the bits below trap_idx_o set.
- R2: If the lowest faulting element f lies above the first active element, and neither the always-trap bit nor escalation applies, no trap is taken. In that case new_vl_o is f.
- R3: Responses may arrive in any order. The truncation point and the trap index are always the lowest faulting element index, never the earliest fault in time.
- R4: At completion, bit i of mask_o is 1 exactly when i < new_vl_o. Elements at or above the first fault are therefore invalid even when they were accessible.
- R5: With the always-trap bit set, a fault on any element above the first active one traps with that element's index instead of truncating.
- R6: The probe counter works as follows:
  - Each load that truncates adds one to the counter. The counter saturates at 2^CNT_W-1 and keeps counting while the threshold is 0.
  - The counter clears on cnt_clr_i.
  - A threshold of 0 disables escalation.
  - With a threshold T > 0 and a count of at least T, a load that would truncate traps instead and leaves the counter unchanged.
- R7: Restrict mode encodings are 0 off, 1 unconditional, 2 armed once escalation applies (R6) and 3 off. When restrict is active and the resume index is 0 with vl ≥ 1, only element 0 is requested. A success then completes with new_vl_o = 1, and a fault traps with index 0.
- R8: A nonzero resume index vs starts the requests at element vs. A fault at element vs traps with trap_idx_o = vs, in both normal and always-trap modes.
- R9: A start with vl = 0 issues no request, takes no trap and leaves the counter unchanged. It completes with new_vl_o = 0 and mask_o = 0.
- R10: The request port and the result behave as follows:
  - The address of request idx is base + idx*ELEM_BYTES.
  - A request is held while it is not accepted.
  - done_o is high for exactly one cycle, and trap_o is high only together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pol_we_i | input | 1 | Load the policy registers |
| pol_thresh_i | input | CNT_W | Probe threshold, 0 disables escalation |
| pol_rmode_i | input | 2 | Restrict mode: 0 off, 1 unconditional, 2 armed, 3 off |
| pol_trap_all_i | input | 1 | Always-trap bit |
| cnt_clr_i | input | 1 | Synchronous clear of the probe counter |
| start_i | input | 1 | Start a load, accepted only when idle |
| base_i | input | ADDR_W | Base address |
| vl_i | input | VL_W | Requested vector length, clamped to VLMAX |
| vstart_i | input | VL_W | Resume index |
| req_valid_o | output | 1 | Element request valid |
| req_ready_i | input | 1 | Port accepts the request |
| req_addr_o | output | ADDR_W | Element address |
| req_idx_o | output | IDX_W | Element index |
| rsp_valid_i | input | 1 | Response valid |
| rsp_idx_i | input | IDX_W | Element index of the response |
| rsp_fault_i | input | 1 | The element faulted |
| done_o | output | 1 | One-cycle result strobe |
| new_vl_o | output | VL_W | Resulting vector length |
| mask_o | output | VLMAX | Valid element mask |
| trap_o | output | 1 | Trap taken |
| trap_idx_o | output | IDX_W | Index of the trapping element |

## Verification
The first request is visible in the cycle after the clock edge that accepts start. The result strobe follows the edge that accepts the last response by exactly two edges. For a zero-length load, the strobe follows the start edge by two edges. The bench drives inputs on the falling edge and waits the same fixed two falling edges before sampling done_o and the result. It then checks on the next falling edge that the strobe has dropped. This makes any extra or missing pipeline stage visible as a failure, not a tolerated delay.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ffl_state_e;

  localparam logic [1:0] RMODE_OFF    = 2'd0;
  localparam logic [1:0] RMODE_ALWAYS = 2'd1;
  localparam logic [1:0] RMODE_ARMED  = 2'd2;
endpackage

// File: rtl/ffl_issue.sv
module ffl_issue #(
  parameter int VLMAX      = 8,
  parameter int ADDR_W     = 16,
  parameter int ELEM_BYTES = 4,
  localparam int VL_W  = $clog2(VLMAX + 1),
  localparam int IDX_W = $clog2(VLMAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [VL_W-1:0]   first_i,
  input  logic [VL_W-1:0]   end_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [IDX_W-1:0]  req_idx_o
);
  function automatic logic [ADDR_W-1:0] elem_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [VL_W-1:0] idx);
    return base + ADDR_W'(idx) * ADDR_W'(ELEM_BYTES);
  endfunction

  logic [VL_W-1:0]   ptr_q, end_q;
  logic [ADDR_W-1:0] base_q;
  logic              issue_fire;

  assign req_valid_o = ptr_q < end_q;
  assign req_idx_o   = ptr_q[IDX_W-1:0];
  assign req_addr_o  = elem_addr(base_q, ptr_q);
  assign issue_fire  = req_valid_o && req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      end_q  <= '0;
      base_q <= '0;
    end else if (launch_i) begin
      ptr_q  <= first_i;
      end_q  <= end_i;
      base_q <= base_i;
    end else if (issue_fire) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  // R10: element indices climb by one per accepted request
  a_r10_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_fire && !launch_i) |=> (!req_valid_o || req_idx_o == IDX_W'($past(req_idx_o) + 1'b1)));
  // R10: a stalled request is held unchanged
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && !launch_i) |=> (req_valid_o && $stable(req_addr_o)));
endmodule

// File: rtl/ffl_collect.sv
module ffl_collect #(
  parameter int VLMAX = 8,
  localparam int VL_W  = $clog2(VLMAX + 1),
  localparam int IDX_W = $clog2(VLMAX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [VL_W-1:0]  expect_i,
  input  logic             rsp_valid_i,
  input  logic [IDX_W-1:0] rsp_idx_i,
  input  logic             rsp_fault_i,
  output logic [VLMAX-1:0] fault_vec_o,
  output logic             all_back_o
);
  logic [VL_W-1:0]  rcv_q, exp_q;
  logic [VLMAX-1:0] fault_q;
  logic             fault_hit;

  assign fault_hit   = rsp_valid_i && rsp_fault_i && (int'(rsp_idx_i) < VLMAX);
  assign fault_vec_o = fault_q;
  assign all_back_o  = rcv_q == exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcv_q   <= '0;
      exp_q   <= '0;
      fault_q <= '0;
    end else if (launch_i) begin
      rcv_q   <= '0;
      exp_q   <= expect_i;
      fault_q <= '0;
    end else begin
      if (rsp_valid_i) rcv_q <= rcv_q + 1'b1;
      if (fault_hit) fault_q[rsp_idx_i] <= 1'b1;
    end
  end

  // R3: fault flags stay sticky until the next load starts
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_i |=> ((fault_vec_o & $past(fault_vec_o)) == $past(fault_vec_o)));
  // R3: never more responses than requests issued
  a_r3_no_excess: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && !launch_i) |-> (rcv_q < exp_q));
endmodule

// File: rtl/ffl_policy.sv
module ffl_policy
  import ffl_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pol_we_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [1:0]       rmode_i,
  input  logic             trap_all_i,
  input  logic             cnt_clr_i,
  input  logic             trunc_evt_i,
  output logic             escalate_o,
  output logic             restrict_o,
  output logic             trap_all_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, thr_q;
  logic [1:0]       rmode_q;
  logic             trap_all_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q      <= '0;
      rmode_q    <= RMODE_OFF;
      trap_all_q <= 1'b0;
    end else if (pol_we_i) begin
      thr_q      <= thresh_i;
      rmode_q    <= rmode_i;
      trap_all_q <= trap_all_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_clr_i) cnt_q <= '0;
    else if (trunc_evt_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign escalate_o = (thr_q != '0) && (cnt_q >= thr_q);
  assign restrict_o = (rmode_q == RMODE_ALWAYS) || ((rmode_q == RMODE_ARMED) && escalate_o);
  assign trap_all_o = trap_all_q;

  // R6: the counter never wraps
  a_r6_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !cnt_clr_i) |=> (cnt_q == CNT_MAX));
  // R6: the counter moves only on a truncation or a clear
  a_r6_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clr_i && !trunc_evt_i) |=> $stable(cnt_q));
  // R6: an escalated load never truncates
  a_r6_no_trunc_escalated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    escalate_o |-> !trunc_evt_i);
endmodule

// File: rtl/ffirst_load_seq.sv
module ffirst_load_seq
  import ffl_pkg::*;
#(
  parameter int VLMAX      = 8,
  parameter int ADDR_W     = 16,
  parameter int ELEM_BYTES = 4,
  parameter int CNT_W      = 3,
  localparam int VL_W  = $clog2(VLMAX + 1),
  localparam int IDX_W = $clog2(VLMAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pol_we_i,
  input  logic [CNT_W-1:0]  pol_thresh_i,
  input  logic [1:0]        pol_rmode_i,
  input  logic              pol_trap_all_i,
  input  logic              cnt_clr_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [VL_W-1:0]   vstart_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [IDX_W-1:0]  req_idx_o,
  input  logic              rsp_valid_i,
  input  logic [IDX_W-1:0]  rsp_idx_i,
  input  logic              rsp_fault_i,
  output logic              done_o,
  output logic [VL_W-1:0]   new_vl_o,
  output logic [VLMAX-1:0]  mask_o,
  output logic              trap_o,
  output logic [IDX_W-1:0]  trap_idx_o
);
  localparam logic [VL_W-1:0] VLMAX_V = VL_W'(VLMAX);

  function automatic logic [VL_W-1:0] lowest_set(input logic [VLMAX-1:0] v);
    logic [VL_W-1:0] r;
    r = VLMAX_V;
    for (int i = VLMAX - 1; i >= 0; i--) if (v[i]) r = VL_W'(i);
    return r;
  endfunction

  function automatic logic [VLMAX-1:0] low_ones(input logic [VL_W-1:0] n);
    logic [VLMAX-1:0] m;
    for (int i = 0; i < VLMAX; i++) m[i] = (VL_W'(i) < n);
    return m;
  endfunction

  ffl_state_e       state_q;
  logic [VL_W-1:0]  vl_q, vs_q;
  logic             rs_q;

  // named internal events
  logic             launch, fin, trunc_evt, trap_take, has_fault;
  logic             escalate, restrict_on, trap_all, all_back;
  logic [VL_W-1:0]  vl_eff, end_now, expect_now, first_f, dec_vl;
  logic             rs_now;
  logic [VLMAX-1:0] fault_vec, dec_mask;

  assign launch     = (state_q == ST_IDLE) && start_i;
  assign fin        = state_q == ST_FIN;
  assign vl_eff     = (vl_i > VLMAX_V) ? VLMAX_V : vl_i;
  assign rs_now     = restrict_on && (vstart_i == '0) && (vl_eff != '0);
  assign end_now    = rs_now ? VL_W'(1) : vl_eff;
  assign expect_now = (end_now > vstart_i) ? (end_now - vstart_i) : '0;

  ffl_policy #(.CNT_W(CNT_W)) u_policy (
    .clk_i, .rst_ni, .pol_we_i,
    .thresh_i(pol_thresh_i), .rmode_i(pol_rmode_i), .trap_all_i(pol_trap_all_i),
    .cnt_clr_i, .trunc_evt_i(trunc_evt),
    .escalate_o(escalate), .restrict_o(restrict_on), .trap_all_o(trap_all)
  );

  ffl_issue #(.VLMAX(VLMAX), .ADDR_W(ADDR_W), .ELEM_BYTES(ELEM_BYTES)) u_issue (
    .clk_i, .rst_ni, .launch_i(launch), .base_i,
    .first_i(vstart_i), .end_i(end_now), .req_ready_i,
    .req_valid_o, .req_addr_o, .req_idx_o
  );

  ffl_collect #(.VLMAX(VLMAX)) u_collect (
    .clk_i, .rst_ni, .launch_i(launch), .expect_i(expect_now),
    .rsp_valid_i, .rsp_idx_i, .rsp_fault_i,
    .fault_vec_o(fault_vec), .all_back_o(all_back)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vl_q    <= '0;
      vs_q    <= '0;
      rs_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          vl_q    <= vl_eff;
          vs_q    <= vstart_i;
          rs_q    <= rs_now;
        end
        ST_RUN:  if (all_back) state_q <= ST_FIN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // decision on the lowest faulting element, independent of arrival order
  assign first_f   = lowest_set(fault_vec);
  assign has_fault = first_f != VLMAX_V;
  assign trap_take = has_fault && ((first_f == vs_q) || trap_all || escalate);
  assign trunc_evt = fin && has_fault && !trap_take;

  always_comb begin
    if (!has_fault)    dec_vl = rs_q ? VL_W'(1) : vl_q;
    else if (trap_take) dec_vl = vl_q;
    else               dec_vl = first_f;
    dec_mask = low_ones(has_fault ? first_f : dec_vl);
  end

  logic             done_q, trap_q;
  logic [VL_W-1:0]  new_vl_q;
  logic [VLMAX-1:0] mask_q;
  logic [IDX_W-1:0] tidx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      trap_q   <= 1'b0;
      new_vl_q <= '0;
      mask_q   <= '0;
      tidx_q   <= '0;
    end else begin
      done_q <= fin;
      trap_q <= fin && trap_take;
      if (fin) begin
        new_vl_q <= dec_vl;
        mask_q   <= dec_mask;
        tidx_q   <= trap_take ? first_f[IDX_W-1:0] : '0;
      end
    end
  end

  assign done_o     = done_q;
  assign trap_o     = trap_q;
  assign new_vl_o   = new_vl_q;
  assign mask_o     = mask_q;
  assign trap_idx_o = tidx_q;

  // R10: one-cycle result strobe
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10: trap only with the strobe
  a_r10_trap_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> done_o);
  // R4: valid mask is a run of ones from element 0
  a_r4_mask_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((mask_o & (mask_o + 1'b1)) == '0));
  // R2: completion never grows vl
  a_r2_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !trap_o) |-> (new_vl_o <= vl_q));
  // R1: trap index lies in the active range
  a_r1_trap_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (VL_W'(trap_idx_o) >= vs_q && VL_W'(trap_idx_o) < vl_q));
  // R9: an empty load issues nothing
  a_r9_empty_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && vl_eff == '0) |=> !req_valid_o);
endmodule

// File: tb/ffirst_load_seq_tb_top.sv
module ffirst_load_seq_tb_top;
  localparam int VLMAX = 8;
  localparam int ADDR_W = 16;
  localparam int EB = 4;
  localparam int CNT_W = 3;
  localparam int VL_W = $clog2(VLMAX + 1);
  localparam int IDX_W = $clog2(VLMAX);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol_we = 0, trap_all = 0, cnt_clr = 0, start = 0;
  logic [CNT_W-1:0] thresh = 0;
  logic [1:0] rmode = 0;
  logic [ADDR_W-1:0] base = 0;
  logic [VL_W-1:0] vl = 0, vstart = 0;
  logic req_valid, req_ready = 0;
  logic [ADDR_W-1:0] req_addr;
  logic [IDX_W-1:0] req_idx;
  logic rsp_valid = 0, rsp_fault = 0;
  logic [IDX_W-1:0] rsp_idx = 0;
  logic done, trap;
  logic [VL_W-1:0] new_vl;
  logic [VLMAX-1:0] mask;
  logic [IDX_W-1:0] trap_idx;

  always #5 clk = ~clk;

  ffirst_load_seq #(.VLMAX(VLMAX), .ADDR_W(ADDR_W), .ELEM_BYTES(EB), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pol_we_i(pol_we), .pol_thresh_i(thresh),
    .pol_rmode_i(rmode), .pol_trap_all_i(trap_all), .cnt_clr_i(cnt_clr),
    .start_i(start), .base_i(base), .vl_i(vl), .vstart_i(vstart),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .req_idx_o(req_idx), .rsp_valid_i(rsp_valid), .rsp_idx_i(rsp_idx),
    .rsp_fault_i(rsp_fault), .done_o(done), .new_vl_o(new_vl), .mask_o(mask),
    .trap_o(trap), .trap_idx_o(trap_idx));

  int checks = 0, errors = 0, cycles = 0;
  // bench-side policy model
  int thr_m = 0, mode_m = 0, at_m = 0, cnt_m = 0;
  // expected outcome
  int e_vl, e_trap, e_idx, e_n, e_trunc;
  logic [VLMAX-1:0] e_mask;
  string e_tag;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [VLMAX-1:0] ones(input int n);
    logic [VLMAX-1:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic model(input int l, input int s, input logic [VLMAX-1:0] fm);
    int esc, rs, endi, f;
    esc = (thr_m != 0 && cnt_m >= thr_m);
    rs = ((mode_m == 1) || (mode_m == 2 && esc)) && s == 0 && l != 0;
    endi = rs ? 1 : l;
    e_n = (endi > s) ? endi - s : 0;
    f = -1;
    for (int i = s; i < endi; i++) if (f < 0 && fm[i]) f = i;
    e_trunc = 0; e_trap = 0; e_idx = 0;
    if (f < 0) begin
      e_vl = rs ? 1 : l;
      e_mask = ones(e_vl);
      e_tag = rs ? "R7" : (l == 0 ? "R9" : "R4");
    end else if (f == s || at_m != 0 || esc) begin
      e_trap = 1; e_idx = f; e_vl = l; e_mask = ones(f);
      if (f == s) e_tag = (s > 0) ? "R8" : (rs ? "R7/R1" : "R1");
      else if (at_m != 0) e_tag = "R5";
      else e_tag = "R6";
    end else begin
      e_trunc = 1; e_vl = f; e_mask = ones(f);
      e_tag = (s > 0) ? "R8/R2" : "R2/R3/R4";
    end
  endtask

  task automatic wr_pol(input int t, input int m, input int a);
    @(negedge clk);
    pol_we = 1; thresh = CNT_W'(t); rmode = 2'(m); trap_all = a[0];
    @(negedge clk);
    pol_we = 0;
    thr_m = t; mode_m = m; at_m = a;
  endtask

  task automatic clr_cnt();
    @(negedge clk); cnt_clr = 1;
    @(negedge clk); cnt_clr = 0;
    cnt_m = 0;
  endtask

  task automatic run_op(input int b, input int l, input int s, input logic [VLMAX-1:0] fm, input int ord);
    int got, guard, n;
    int ids[VLMAX];
    bit bad_req;
    model(l, s, fm);
    n = e_n;
    bad_req = 0;
    @(negedge clk);
    start = 1; base = ADDR_W'(b); vl = VL_W'(l); vstart = VL_W'(s);
    @(negedge clk);
    start = 0;
    got = 0; guard = 0;
    while (got < n && guard < 200) begin
      req_ready = (guard % 3) != 2;
      if (req_valid && req_ready) begin
        if (int'(req_idx) != s + got || int'(req_addr) != ((b + (s + got) * EB) & 16'hFFFF)) bad_req = 1;
        ids[got] = int'(req_idx);
        got++;
      end
      @(negedge clk);
      guard++;
    end
    req_ready = 0;
    check(got == n && !bad_req, "R10", "request count/address", got, n);
    for (int k = 0; k < n; k++) begin
      int j;
      j = (ord == 0) ? (n - 1 - k) : ((k + n / 2) % n);
      rsp_valid = 1; rsp_idx = IDX_W'(ids[j]); rsp_fault = fm[ids[j]];
      @(negedge clk);
    end
    rsp_valid = 0; rsp_fault = 0;
    check(!req_valid, "R10", "no stray request", int'(req_valid), 0);
    @(negedge clk);
    check(!done, e_tag, "early done", int'(done), 0);
    @(negedge clk);
    check(done == 1 && int'(new_vl) == e_vl, e_tag, "new_vl at done", int'(new_vl), e_vl);
    check(mask == e_mask, e_tag, "mask", int'(mask), int'(e_mask));
    check(int'(trap) == e_trap && (e_trap == 0 || int'(trap_idx) == e_idx), e_tag, "trap/idx",
          int'(trap) * 16 + int'(trap_idx), e_trap * 16 + e_idx);
    @(negedge clk);
    check(!done && !trap, "R10", "strobe length", int'(done), 0);
    if (e_trunc != 0 && cnt_m < (1 << CNT_W) - 1) cnt_m++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !trap && !req_valid, "R10", "reset state", int'(done) + int'(trap) + int'(req_valid), 0);
    rst_n = 1;
    @(negedge clk);

    // normal mode, resume index 0, every vl and every fault pattern (R1 R2 R3 R4 R9)
    wr_pol(0, 0, 0);
    for (int l = 0; l <= VLMAX; l++)
      for (int fm = 0; fm < (1 << l); fm++)
        run_op(16'h1000 + l * 16, l, 0, VLMAX'(fm), (fm + l) % 2);

    // always-trap mode over every resume index (R5 R8)
    wr_pol(0, 0, 1);
    for (int s = 0; s < VLMAX; s++)
      for (int fm = 0; fm < 256; fm++)
        run_op(16'hFFF0, VLMAX, s, VLMAX'(fm), fm % 2);

    // normal mode resuming at 3 (R8)
    wr_pol(0, 0, 0);
    for (int fm = 0; fm < 256; fm++) run_op(16'h2000, VLMAX, 3, VLMAX'(fm), fm % 2);

    // probe counter threshold and clear (R6)
    clr_cnt();
    wr_pol(3, 0, 0);
    for (int k = 0; k < 4; k++) run_op(16'h300, 8, 0, 8'h10, k % 2);
    clr_cnt();
    run_op(16'h300, 8, 0, 8'h30, 0);
    wr_pol(0, 0, 0);
    for (int k = 0; k < 9; k++) run_op(16'h340, 6, 0, 8'h08, 1);
    wr_pol(2, 0, 0);
    run_op(16'h340, 6, 0, 8'h08, 0);

    // restrict mode unconditional (R7)
    clr_cnt();
    wr_pol(0, 1, 0);
    run_op(16'h400, 5, 0, 8'h1E, 0);
    run_op(16'h400, 5, 0, 8'h01, 0);
    run_op(16'h400, 5, 2, 8'h08, 1);
    // restrict mode armed after threshold, then encoding 3 (R7)
    clr_cnt();
    wr_pol(2, 2, 0);
    run_op(16'h500, 6, 0, 8'h04, 0);
    run_op(16'h500, 6, 0, 8'h04, 1);
    run_op(16'h500, 6, 0, 8'h04, 0);
    clr_cnt();
    wr_pol(0, 3, 0);
    run_op(16'h500, 6, 0, 8'h04, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule